// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a small three-wire serial EEPROM. It drives the memory's select, shift clock and serial input lines, and it samples the memory's serial output. A one-cycle start request carries an operation code and a word address. The block returns its result with a single-cycle done pulse, and meanwhile it holds busy high.

The block supports three operations:
- A plain word read.
- A width probe. It reads word 0 with an 8-bit address and, from the value returned, decides whether later commands carry 6 or 8 address bits.
- A station-address fetch. It reads three consecutive words and assembles a 48-bit address from them, swapping the byte order of each word.

Every bit period consists of two phases. The length of each phase is set in system clocks by a parameter, so the serial clock can be matched to slow memories.

Top module: `uwr_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low, and `addr_wide` is 0, which selects 6 address bits.
- R2: Each read command is shifted MSB first. It consists of two zero bits, then 1, 1, 0, then the word address in 6 bits (`addr_wide`=0) or 8 bits (`addr_wide`=1).
- R3: Within one select window the shift clock rises exactly 5 + width + 16 times. The shift clock is never high while select is low.
- R4: `ee_di` changes only while the shift clock is low. It is stable across every rising edge of the shift clock.
- R5: After the command, 16 data bits are sampled while the shift clock is high, MSB first, and are returned on `rd_word`.
- R6: Operation code 1 reads word 0 with an 8-bit address. `addr_wide` becomes 1 if that word equals 0x8129 and 0 otherwise, and it keeps that value until the next probe or reset.
- R7: Operation code 2 reads words 7, 8 and 9. `station_addr` becomes {w7[7:0], w7[15:8], w8[7:0], w8[15:8], w9[7:0], w9[15:8]}, and `rd_word` is unchanged.
- R8: Each word of the station fetch is a separate access, and select returns low between the accesses.
- R9: A start request that arrives while `busy` is high is ignored. It does not change the running access, the number of accesses or any result.
- R10: `done` is a single-cycle pulse that occurs with `busy` low. `busy` is high from the cycle after an accepted start until the done cycle.
- R11: Every phase lasts `HALF_CYC` system clocks, so rising shift-clock edges within an access are 2·`HALF_CYC` clocks apart.
- R12: Operation codes 0 and 3 both perform a plain read of `addr` at the current width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| op | input | 2 | 0/3 read, 1 width probe, 2 station fetch |
| addr | input | 8 | Word address for a plain read |
| ee_do | input | 1 | Serial data from the memory |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Shift clock |
| ee_di | output | 1 | Serial data to the memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one cycle |
| rd_word | output | 16 | Last word read by a read or probe |
| station_addr | output | 48 | Assembled station address |
| addr_wide | output | 1 | 1 selects 8 address bits, 0 selects 6 |

## Verification
The assertions check several properties on every cycle:
- The shift clock stays inside the select window.
- The data line is stable across each rising edge.
- The count of rising edges per access matches the width in use.
- Phase ticks are spaced correctly.
- `done` is a single-cycle pulse with `busy` low.
- A request made while busy never launches an access.

The bench scenarios cover what the assertions cannot. A memory model decodes the command bits and checks the address values and the result words. It also shows that the width decision taken from word 0 changes how later addresses are sent. Finally, it checks the byte order of the station address and confirms that an ignored request leaves every result untouched.

// File: rtl/uwr_pkg.sv
`timescale 1ns/1ps
package uwr_pkg;
  localparam int UWR_NAW       = 6;
  localparam int UWR_WAW       = 8;
  localparam int UWR_DW        = 16;
  localparam logic [15:0] UWR_SIG = 16'h8129;
  localparam int UWR_STN_BASE  = 7;
  localparam int UWR_STN_WORDS = 3;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_PROBE   = 2'd1,
    OP_STATION = 2'd2,
    OP_READ_B  = 2'd3
  } uwr_op_e;

  typedef enum logic [2:0] {
    X_IDLE, X_SEL, X_CMD, X_GAP, X_DATA, X_END
  } uwr_xst_e;
endpackage

// File: rtl/uwr_tick.sv
`timescale 1ns/1ps
module uwr_tick #(
  parameter int HALF_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_CYC > 1) begin : g_chk
      p_tick_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/uwr_xfer.sv
`timescale 1ns/1ps
module uwr_xfer
  import uwr_pkg::*;
#(
  parameter int NAW = UWR_NAW,
  parameter int WAW = UWR_WAW,
  parameter int DW  = UWR_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           go,
  input  logic [WAW-1:0] addr,
  input  logic           wide,
  input  logic           ee_do,
  output logic           run,
  output logic           ee_cs,
  output logic           ee_sk,
  output logic           ee_di,
  output logic [DW-1:0]  word,
  output logic           fin
);
  localparam int CMD_W   = 5 + WAW;
  localparam int CNT_MAX = (CMD_W > DW) ? CMD_W : DW;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int EDG_W   = $clog2(CMD_W + DW + 1);

  uwr_xst_e          st_q, st_d;
  logic              ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic              cs_q, sk_q, di_q, fin_q;
  logic              cs_d, sk_d, di_d, fin_d;
  logic [CMD_W-1:0]  cmd_wide, cmd_narrow;

  assign cmd_wide   = {2'b00, 3'b110, addr};
  assign cmd_narrow = CMD_W'({3'b110, addr[NAW-1:0]});

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    sh_d  = sh_q;
    fin_d = 1'b0;
    unique case (st_q)
      X_IDLE: if (go) begin
        st_d  = X_SEL;
        cmd_d = wide ? cmd_wide : cmd_narrow;
        cnt_d = wide ? CNT_W'(CMD_W - 1) : CNT_W'(NAW + 4);
      end
      X_SEL: if (tick) begin
        st_d = X_CMD;
        ph_d = 1'b0;
      end
      X_CMD: if (tick) begin
        if (!ph_q) ph_d = 1'b1;
        else begin
          ph_d = 1'b0;
          if (cnt_q == '0) st_d = X_GAP;
          else             cnt_d = cnt_q - 1'b1;
        end
      end
      X_GAP: if (tick) begin
        st_d  = X_DATA;
        ph_d  = 1'b0;
        cnt_d = CNT_W'(DW - 1);
      end
      X_DATA: if (tick) begin
        if (!ph_q) begin
          ph_d = 1'b1;
          sh_d = {sh_q[DW-2:0], ee_do};
        end else begin
          ph_d = 1'b0;
          if (cnt_q == '0) st_d = X_END;
          else             cnt_d = cnt_q - 1'b1;
        end
      end
      X_END: if (tick) begin
        st_d  = X_IDLE;
        fin_d = 1'b1;
      end
      default: st_d = X_IDLE;
    endcase
    cs_d = (st_d == X_SEL) || (st_d == X_CMD) || (st_d == X_GAP) || (st_d == X_DATA);
    sk_d = ((st_d == X_CMD) && ph_d) || ((st_d == X_DATA) && !ph_d);
    di_d = (st_d == X_CMD) ? cmd_d[cnt_d] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= X_IDLE;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      cmd_q <= '0;
      sh_q  <= '0;
      cs_q  <= 1'b0;
      sk_q  <= 1'b0;
      di_q  <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
      sh_q  <= sh_d;
      cs_q  <= cs_d;
      sk_q  <= sk_d;
      di_q  <= di_d;
      fin_q <= fin_d;
    end
  end

  assign run   = (st_q != X_IDLE);
  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign word  = sh_q;
  assign fin   = fin_q;

  // Edge-count checker for one select window
  logic [EDG_W-1:0] chk_edges;
  logic             chk_sk_d, chk_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_edges <= '0;
      chk_sk_d  <= 1'b0;
      chk_wide  <= 1'b0;
    end else begin
      chk_sk_d <= ee_sk;
      if (go && (st_q == X_IDLE)) chk_wide <= wide;
      if (!ee_cs)                  chk_edges <= '0;
      else if (ee_sk && !chk_sk_d) chk_edges <= chk_edges + 1'b1;
    end
  end

  p_sk_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  p_edge_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (chk_edges == (chk_wide ? EDG_W'(CMD_W + DW) : EDG_W'(NAW + 5 + DW))));
  p_di_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> $stable(ee_di));
endmodule

// File: rtl/uwr_reader.sv
`timescale 1ns/1ps
module uwr_reader
  import uwr_pkg::*;
#(
  parameter int HALF_CYC = 200,
  parameter int NAW      = UWR_NAW,
  parameter int WAW      = UWR_WAW,
  parameter int DW       = UWR_DW,
  parameter int NWORDS   = UWR_STN_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WAW-1:0]   addr,
  input  logic             ee_do,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_word,
  output logic [NWORDS*DW-1:0] station_addr,
  output logic             addr_wide
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [WAW-1:0] STN_BASE = WAW'(UWR_STN_BASE);

  // Reset: asserted asynchronously, released on the clock
  logic rs_a, rs_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  logic srst_n;
  assign srst_n = rs_b;

  logic           x_run, x_tick, x_fin;
  logic [DW-1:0]  x_word;

  logic              busy_q, busy_d, done_q, done_d, go_q, go_d;
  logic              xwide_q, xwide_d, wide_q, wide_d;
  uwr_op_e           op_q, op_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WAW-1:0]    xaddr_q, xaddr_d;
  logic [DW-1:0]     rd_q, rd_d;
  logic [NWORDS*DW-1:0] mac_q, mac_d;

  uwr_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(x_run), .tick(x_tick)
  );

  uwr_xfer #(.NAW(NAW), .WAW(WAW), .DW(DW)) u_xfer (
    .clk(clk), .rst_n(srst_n), .tick(x_tick), .go(go_q),
    .addr(xaddr_q), .wide(xwide_q), .ee_do(ee_do), .run(x_run),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .word(x_word), .fin(x_fin)
  );

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    go_d    = 1'b0;
    op_d    = op_q;
    idx_d   = idx_q;
    xaddr_d = xaddr_q;
    xwide_d = xwide_q;
    wide_d  = wide_q;
    rd_d    = rd_q;
    mac_d   = mac_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        go_d   = 1'b1;
        op_d   = uwr_op_e'(op);
        idx_d  = '0;
        unique case (uwr_op_e'(op))
          OP_PROBE: begin
            xaddr_d = '0;
            xwide_d = 1'b1;
          end
          OP_STATION: begin
            xaddr_d = STN_BASE;
            xwide_d = wide_q;
          end
          default: begin
            xaddr_d = addr;
            xwide_d = wide_q;
          end
        endcase
      end
    end else if (x_fin) begin
      unique case (op_q)
        OP_PROBE: begin
          rd_d   = x_word;
          wide_d = (x_word == UWR_SIG);
          busy_d = 1'b0;
          done_d = 1'b1;
        end
        OP_STATION: begin
          mac_d[(NWORDS - 1 - int'(idx_q))*DW +: DW] = {x_word[7:0], x_word[DW-1:8]};
          if (idx_q == IDX_W'(NWORDS - 1)) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            idx_d   = idx_q + 1'b1;
            xaddr_d = xaddr_q + 1'b1;
            go_d    = 1'b1;
          end
        end
        default: begin
          rd_d   = x_word;
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      go_q    <= 1'b0;
      op_q    <= OP_READ;
      idx_q   <= '0;
      xaddr_q <= '0;
      xwide_q <= 1'b0;
      wide_q  <= 1'b0;
      rd_q    <= '0;
      mac_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      go_q    <= go_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      xaddr_q <= xaddr_d;
      xwide_q <= xwide_d;
      wide_q  <= wide_d;
      rd_q    <= rd_d;
      mac_q   <= mac_d;
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign rd_word      = rd_q;
  assign station_addr = mac_q;
  assign addr_wide    = wide_q;

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);
  p_cs_busy_r8: assert property (@(posedge clk) disable iff (!srst_n)
    ee_cs |-> busy);
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && start && !x_fin) |=> !go_q);
endmodule

// File: tb/uwr_reader_test.sv
`timescale 1ns/1ps
module uwr_reader_test;
  localparam int HALF = 4;
  localparam real SK_PERIOD = 2.0 * HALF * 5.0;

  logic        clk, rst_n, start, ee_do;
  logic [1:0]  op;
  logic [7:0]  addr;
  logic        ee_cs, ee_sk, ee_di, busy, done, addr_wide;
  logic [15:0] rd_word;
  logic [47:0] station_addr;

  int nchk = 0;
  int nerr = 0;

  uwr_reader #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .busy(busy), .done(done), .rd_word(rd_word),
    .station_addr(station_addr), .addr_wide(addr_wide)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Memory model
  bit         chip_wide = 0;
  int         m_stage, m_cnt, m_lead, m_edges;
  int         m_sessions = 0;
  logic [1:0] m_op;
  logic [7:0] m_addr;
  logic [15:0] m_word;
  real        t_last, d_min, d_max;
  bit         have_t;

  function automatic logic [15:0] mem_word(input logic [7:0] a, input bit w);
    if (a == 8'h00) return w ? 16'h8129 : 16'h0123;
    return 16'h1000 + {8'h00, a} * 16'h0357;
  endfunction

  initial ee_do = 1'b0;

  always @(posedge ee_cs or posedge ee_sk) begin
    if (!ee_sk) begin
      m_stage = 0; m_cnt = 0; m_lead = 0; m_edges = 0;
      m_op = 2'b00; m_addr = 8'h00; have_t = 0;
      d_min = 1.0e9; d_max = 0.0;
      m_sessions = m_sessions + 1;
    end else if (ee_cs) begin
      m_edges = m_edges + 1;
      if (have_t) begin
        if ($realtime - t_last < d_min) d_min = $realtime - t_last;
        if ($realtime - t_last > d_max) d_max = $realtime - t_last;
      end
      t_last = $realtime;
      have_t = 1;
      case (m_stage)
        0: if (ee_di) m_stage = 1; else m_lead = m_lead + 1;
        1: begin
          m_op = {m_op[0], ee_di};
          m_cnt = m_cnt + 1;
          if (m_cnt == 2) begin m_stage = 2; m_cnt = 0; end
        end
        2: begin
          m_addr = {m_addr[6:0], ee_di};
          m_cnt = m_cnt + 1;
          if (m_cnt == (chip_wide ? 8 : 6)) begin
            m_stage = 3; m_cnt = 0;
            m_word = mem_word(m_addr, chip_wide);
            ee_do <= 1'b0;
          end
        end
        default: begin
          ee_do <= (m_cnt < 16) ? m_word[15 - m_cnt] : 1'b0;
          m_cnt = m_cnt + 1;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // Watchdog
  initial begin
    #900000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic pulse_start(input logic [1:0] o, input logic [7:0] a);
    @(negedge clk);
    start = 1'b1; op = o; addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, req, "done seen", {63'd0, done}, 64'd1);
    check(busy === 1'b0, "R10", "busy low with done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R10", "done single cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; op = 2'd0; addr = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} === 5'b0, "R1", "idle outputs",
          {59'd0, ee_cs, ee_sk, ee_di, busy, done}, 64'd0);
    check(addr_wide === 1'b0, "R1", "narrow after reset", {63'd0, addr_wide}, 64'd0);
  endtask

  task automatic t_read(input logic [1:0] o, input logic [7:0] a, input string req);
    int s0, aw;
    logic [7:0] am;
    s0 = m_sessions;
    aw = addr_wide ? 8 : 6;
    am = addr_wide ? a : (a & 8'h3F);
    pulse_start(o, a);
    check(busy === 1'b1, "R10", "busy after start", {63'd0, busy}, 64'd1);
    wait_done(req);
    check(rd_word === mem_word(am, chip_wide), req, "R5 word", {48'd0, rd_word},
          {48'd0, mem_word(am, chip_wide)});
    check(m_lead == 2 && m_op == 2'b10, "R2", "leading zeros and opcode",
          {32'(m_lead), 30'd0, m_op}, {32'd2, 30'd0, 2'b10});
    check(m_addr === am, "R2", "address bits", {56'd0, m_addr}, {56'd0, am});
    check(m_edges == 5 + aw + 16, "R3", "clock count", 64'(m_edges), 64'(5 + aw + 16));
    check(d_min == SK_PERIOD && d_max == SK_PERIOD, "R11", "clock period ns",
          64'($rtoi(d_max)), 64'($rtoi(SK_PERIOD)));
    check(m_sessions == s0 + 1, req, "one access", 64'(m_sessions), 64'(s0 + 1));
  endtask

  task automatic t_probe(input bit expect_wide);
    pulse_start(2'd1, 8'hA5);
    wait_done("R6");
    check(addr_wide === expect_wide, "R6", "width decision",
          {63'd0, addr_wide}, {63'd0, expect_wide});
    check(m_edges == 5 + 8 + 16, "R6", "probe uses 8 address bits",
          64'(m_edges), 64'(29));
    if (expect_wide)
      check(rd_word === 16'h8129, "R6", "probe word", {48'd0, rd_word}, 64'h8129);
  endtask

  task automatic t_station();
    int s0;
    logic [15:0] w7, w8, w9, rd0;
    logic [47:0] exp;
    s0 = m_sessions;
    rd0 = rd_word;
    w7 = mem_word(8'd7, chip_wide);
    w8 = mem_word(8'd8, chip_wide);
    w9 = mem_word(8'd9, chip_wide);
    exp = {w7[7:0], w7[15:8], w8[7:0], w8[15:8], w9[7:0], w9[15:8]};
    pulse_start(2'd2, 8'h33);
    wait_done("R7");
    check(station_addr === exp, "R7", "station address", {16'd0, station_addr}, {16'd0, exp});
    check(rd_word === rd0, "R7", "rd_word untouched", {48'd0, rd_word}, {48'd0, rd0});
    check(m_sessions == s0 + 3, "R8", "three select windows", 64'(m_sessions), 64'(s0 + 3));
    check(m_addr === 8'd9, "R8", "last word address", {56'd0, m_addr}, 64'd9);
  endtask

  task automatic t_busy_ignore();
    int s0;
    logic [47:0] st0;
    logic        w0;
    s0 = m_sessions;
    st0 = station_addr;
    w0 = addr_wide;
    pulse_start(2'd0, 8'h11);
    repeat (20) @(negedge clk);
    pulse_start(2'd2, 8'h22);
    repeat (40) @(negedge clk);
    pulse_start(2'd1, 8'h00);
    wait_done("R9");
    check(rd_word === mem_word(8'h11, chip_wide), "R9", "first request result",
          {48'd0, rd_word}, {48'd0, mem_word(8'h11, chip_wide)});
    check(m_sessions == s0 + 1, "R9", "no extra access", 64'(m_sessions), 64'(s0 + 1));
    check(station_addr === st0 && addr_wide === w0, "R9", "other results kept",
          {15'd0, addr_wide, station_addr}, {15'd0, w0, st0});
    repeat (50) @(negedge clk);
    check(busy === 1'b0 && ee_cs === 1'b0, "R9", "stays idle after",
          {62'd0, busy, ee_cs}, 64'd0);
  endtask

  initial begin
    t_reset();
    chip_wide = 0;
    t_read(2'd0, 8'h05, "R5");
    t_read(2'd0, 8'h3F, "R5");
    t_probe(1'b0);
    t_read(2'd0, 8'h2A, "R6");
    chip_wide = 1;
    t_probe(1'b1);
    t_read(2'd0, 8'hC5, "R2");
    t_read(2'd0, 8'hFF, "R5");
    t_read(2'd3, 8'h80, "R12");
    t_station();
    t_busy_ignore();
    finish_run();
  end
endmodule